// File: doc/BRIEF.md
# Conversion Status and Interrupt Flags

This block keeps the status flags of one channel of a multi-channel sigma-delta decimation filter. For each of the two conversion kinds, regular and injected, it holds an end-of-conversion flag and an overrun flag. In the instance for filter 0 it also holds one clock-absence flag and one short-circuit flag for each input channel. Hardware event pulses set the flags. A flag clears in one of three ways: a read strobe on the matching data register, a write-one-to-clear access to the clear word, or dropping the filter enable.

The block also tells the datapath when it may load a new result into a data register. A result that arrives while the previous one is still unread is an overrun, and the register keeps its old contents. A combined interrupt request is raised when any flag is set and its interrupt enable is also set. The flag registers use an asynchronous active-low reset, which the surrounding clock domain releases synchronously.

Top module: `cnv_status_flags`

## Requirements
- R1: After reset, and on the cycle after any cycle with `flt_en` low, all status bits and `irq` are 0. Events, strobes and clear writes made while disabled change nothing, and neither load output is raised.
- R2: Each end-of-conversion flag (injected in status bit 0, regular in bit 1) reads 1 from the cycle after its conversion-done pulse. A read strobe of its own data register clears it. A read strobe while the flag is 0 has no effect.
- R3: A conversion-done pulse that arrives while the matching end-of-conversion flag is 1, with no read strobe in the same cycle, sets the matching overrun flag (injected in bit 2, regular in bit 3) and keeps the data-load output low. In every other enabled case, a done pulse raises the data-load output in that same cycle.
- R4: A clear write with bit 2 set clears the injected overrun flag. A clear write with bit 3 set clears the regular overrun flag. Bits written as 0 have no effect.
- R5: When a set event and a clear of the same flag fall in the same cycle, the flag ends up as 1.
- R6: Clock-absence flag y (status bit 16+y) is set by its event pulse. It is held at 1 while `chan_synced[y]` is 0, and in that state a clear write cannot clear it. When the channel is synchronized, a clear write with bit 16+y set clears it.
- R7: Short-circuit flag y (status bit 24+y) is set by its event pulse. A clear write with bit 24+y set clears it.
- R8: `irq` is 1 exactly when some flag is 1 and its enable bit is also 1. The enable bits are: bit 0 injected end-of-conversion, bit 1 regular end-of-conversion, bit 2 injected overrun, bit 3 regular overrun, bit 4 any clock-absence flag, bit 5 any short-circuit flag.
- R9: Status bits 15:4 always read 0.
- R10: With `IS_FLT0` = 0, status bits 31:16 read 0, and the per-channel events and clear bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_en | input | 1 | Filter enable; low forces all flags to 0 |
| jconv_done | input | 1 | Injected conversion completed (pulse) |
| rconv_done | input | 1 | Regular conversion completed (pulse) |
| jdata_rd | input | 1 | Read strobe of the injected data register |
| rdata_rd | input | 1 | Read strobe of the regular data register (software or DMA) |
| clr_wr | input | 1 | Write strobe of the clear word |
| clr_wdata | input | 32 | Clear word: bit 2 / bit 3 overrun, 23:16 clock absence, 31:24 short circuit |
| ckab_evt | input | NUM_CH | Clock-absence detected, one bit per channel |
| scd_evt | input | NUM_CH | Short circuit detected, one bit per channel |
| chan_synced | input | NUM_CH | Channel transceiver synchronized |
| irq_en | input | 6 | Per-source interrupt enables |
| status | output | 32 | Status word |
| irq | output | 1 | Combined interrupt request |
| jdata_load | output | 1 | Injected data register may take the new result |
| rdata_load | output | 1 | Regular data register may take the new result |

## Verification
The assertions take event, strobe and clear inputs to be synchronous to `clk` and held for whole cycles. They take `chan_synced` to be a level. The stimulus changes every input one time unit after a rising edge and holds it until the next edge. It covers coincident events and clears, reads without a pending flag, and unsynchronized channels, and it compares every cycle of both the filter-0 and the other-filter variant against a flag model built from the requirements.

// File: rtl/cnv_status_pkg.sv
package cnv_status_pkg;
  localparam int unsigned STS_W        = 32;
  localparam int unsigned MAX_CH       = 8;
  localparam int unsigned BIT_JEOC     = 0;
  localparam int unsigned BIT_REOC     = 1;
  localparam int unsigned BIT_JOVR     = 2;
  localparam int unsigned BIT_ROVR     = 3;
  localparam int unsigned CKAB_LSB     = 16;
  localparam int unsigned SCD_LSB      = 24;
  localparam int unsigned NUM_IRQ_SRC  = 6;
  localparam int unsigned IEN_JEOC     = 0;
  localparam int unsigned IEN_REOC     = 1;
  localparam int unsigned IEN_JOVR     = 2;
  localparam int unsigned IEN_ROVR     = 3;
  localparam int unsigned IEN_CKAB     = 4;
  localparam int unsigned IEN_SCD      = 5;
endpackage

// File: rtl/cnv_eoc_ovr.sv
// End-of-conversion and overrun pair for one conversion kind.
module cnv_eoc_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic conv_done,
  input  logic data_rd,
  input  logic ovr_clr,
  output logic eoc,
  output logic ovr,
  output logic data_load
);
  logic eoc_q, eoc_d;
  logic ovr_q, ovr_d;
  logic ovr_hit;

  // A result is lost only if the previous one is pending and not read now.
  always_comb begin
    ovr_hit   = en & conv_done & eoc_q & ~data_rd;
    data_load = en & conv_done & ~ovr_hit;
    if (!en) begin
      eoc_d = 1'b0;
      ovr_d = 1'b0;
    end else begin
      // set has priority over any clear in the same cycle
      eoc_d = conv_done | (eoc_q & ~data_rd);
      ovr_d = ovr_hit   | (ovr_q & ~ovr_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      eoc_q <= eoc_d;
      ovr_q <= ovr_d;
    end
  end

  assign eoc = eoc_q;
  assign ovr = ovr_q;
endmodule

// File: rtl/cnv_chan_flags.sv
// Per-channel clock-absence and short-circuit flags.
module cnv_chan_flags #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [NUM_CH-1:0] ckab_evt,
  input  logic [NUM_CH-1:0] scd_evt,
  input  logic [NUM_CH-1:0] synced,
  input  logic [NUM_CH-1:0] ckab_clr,
  input  logic [NUM_CH-1:0] scd_clr,
  output logic [NUM_CH-1:0] ckab,
  output logic [NUM_CH-1:0] scd
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic ckab_q, ckab_d;
    logic scd_q, scd_d;

    always_comb begin
      if (!en) begin
        ckab_d = 1'b0;
        scd_d  = 1'b0;
      end else begin
        // an unsynchronized channel pins its flag high; clears lose to sets
        ckab_d = ckab_evt[g] | ~synced[g] | (ckab_q & ~ckab_clr[g]);
        scd_d  = scd_evt[g] | (scd_q & ~scd_clr[g]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ckab_q <= 1'b0;
        scd_q  <= 1'b0;
      end else begin
        ckab_q <= ckab_d;
        scd_q  <= scd_d;
      end
    end

    assign ckab[g] = ckab_q;
    assign scd[g]  = scd_q;
  end
endmodule

// File: rtl/cnv_status_flags.sv
module cnv_status_flags
  import cnv_status_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter bit          IS_FLT0 = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flt_en,
  input  logic                   jconv_done,
  input  logic                   rconv_done,
  input  logic                   jdata_rd,
  input  logic                   rdata_rd,
  input  logic                   clr_wr,
  input  logic [STS_W-1:0]       clr_wdata,
  input  logic [NUM_CH-1:0]      ckab_evt,
  input  logic [NUM_CH-1:0]      scd_evt,
  input  logic [NUM_CH-1:0]      chan_synced,
  input  logic [NUM_IRQ_SRC-1:0] irq_en,
  output logic [STS_W-1:0]       status,
  output logic                   irq,
  output logic                   jdata_load,
  output logic                   rdata_load
);
  localparam int unsigned CH_W = (NUM_CH > MAX_CH) ? MAX_CH : NUM_CH;

  logic jeoc, jovr, reoc, rovr;
  logic jovr_clr, rovr_clr;
  logic [NUM_CH-1:0] ckab, scd;
  logic unused_clr_bits;

  assign jovr_clr = clr_wr & clr_wdata[BIT_JOVR];
  assign rovr_clr = clr_wr & clr_wdata[BIT_ROVR];
  assign unused_clr_bits = ^{clr_wdata[CKAB_LSB-1:BIT_ROVR+1], clr_wdata[BIT_REOC:BIT_JEOC]};

  cnv_eoc_ovr u_inj (
    .clk(clk), .rst_n(rst_n), .en(flt_en),
    .conv_done(jconv_done), .data_rd(jdata_rd), .ovr_clr(jovr_clr),
    .eoc(jeoc), .ovr(jovr), .data_load(jdata_load)
  );

  cnv_eoc_ovr u_reg (
    .clk(clk), .rst_n(rst_n), .en(flt_en),
    .conv_done(rconv_done), .data_rd(rdata_rd), .ovr_clr(rovr_clr),
    .eoc(reoc), .ovr(rovr), .data_load(rdata_load)
  );

  if (IS_FLT0) begin : g_chan
    logic [NUM_CH-1:0] ckab_clr, scd_clr;
    assign ckab_clr = clr_wr ? clr_wdata[CKAB_LSB +: NUM_CH] : '0;
    assign scd_clr  = clr_wr ? clr_wdata[SCD_LSB  +: NUM_CH] : '0;

    cnv_chan_flags #(.NUM_CH(NUM_CH)) u_chan (
      .clk(clk), .rst_n(rst_n), .en(flt_en),
      .ckab_evt(ckab_evt), .scd_evt(scd_evt), .synced(chan_synced),
      .ckab_clr(ckab_clr), .scd_clr(scd_clr),
      .ckab(ckab), .scd(scd)
    );
  end else begin : g_nochan
    logic unused_chan;
    assign unused_chan = ^{ckab_evt, scd_evt, chan_synced, clr_wdata[STS_W-1:CKAB_LSB]};
    assign ckab = '0;
    assign scd  = '0;
  end

  always_comb begin
    status                   = '0;
    status[BIT_JEOC]         = jeoc;
    status[BIT_REOC]         = reoc;
    status[BIT_JOVR]         = jovr;
    status[BIT_ROVR]         = rovr;
    status[CKAB_LSB +: CH_W] = ckab[CH_W-1:0];
    status[SCD_LSB  +: CH_W] = scd[CH_W-1:0];
  end

  always_comb begin
    irq = (jeoc    & irq_en[IEN_JEOC])
        | (reoc    & irq_en[IEN_REOC])
        | (jovr    & irq_en[IEN_JOVR])
        | (rovr    & irq_en[IEN_ROVR])
        | ((|ckab) & irq_en[IEN_CKAB])
        | ((|scd)  & irq_en[IEN_SCD]);
  end
endmodule

// File: rtl/cnv_status_flags_chk.sv
module cnv_status_flags_chk
  import cnv_status_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter bit          IS_FLT0 = 1'b1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flt_en,
  input logic                   jconv_done,
  input logic                   rconv_done,
  input logic                   jdata_rd,
  input logic                   rdata_rd,
  input logic [NUM_CH-1:0]      chan_synced,
  input logic [NUM_IRQ_SRC-1:0] irq_en,
  input logic [STS_W-1:0]       status,
  input logic                   irq,
  input logic                   jdata_load,
  input logic                   rdata_load
);
  a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_en |=> (status == '0));

  a_r1_no_load_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_en |-> (!jdata_load && !rdata_load));

  a_r3_inj_overrun_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && jconv_done && status[BIT_JEOC] && !jdata_rd) |-> !jdata_load);

  a_r3_inj_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && jconv_done && status[BIT_JEOC] && !jdata_rd) |=> status[BIT_JOVR]);

  a_r3_reg_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && rconv_done && status[BIT_REOC] && !rdata_rd) |=> status[BIT_ROVR]);

  a_r5_set_wins_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && rconv_done) |=> status[BIT_REOC]);

  a_r5_set_wins_inj: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && jconv_done) |=> status[BIT_JEOC]);

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[CKAB_LSB-1:BIT_ROVR+1] == '0);

  if (IS_FLT0) begin : g_f0
    a_r6_unsynced_held: assert property (@(posedge clk) disable iff (!rst_n)
      flt_en |=> ((status[CKAB_LSB +: NUM_CH] | $past(chan_synced)) == {NUM_CH{1'b1}}));
  end else begin : g_nf
    a_r10_no_chan_flags: assert property (@(posedge clk) disable iff (!rst_n)
      status[STS_W-1:CKAB_LSB] == '0);
  end
endmodule

bind cnv_status_flags cnv_status_flags_chk #(.NUM_CH(NUM_CH), .IS_FLT0(IS_FLT0)) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_en(flt_en),
  .jconv_done(jconv_done), .rconv_done(rconv_done),
  .jdata_rd(jdata_rd), .rdata_rd(rdata_rd),
  .chan_synced(chan_synced), .irq_en(irq_en),
  .status(status), .irq(irq), .jdata_load(jdata_load), .rdata_load(rdata_load)
);

// File: tb/cnv_status_flags_bench.sv
module cnv_status_flags_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic flt_en, jconv_done, rconv_done, jdata_rd, rdata_rd, clr_wr;
  logic [31:0] clr_wdata;
  logic [NCH-1:0] ckab_evt, scd_evt, chan_synced;
  logic [5:0] irq_en;
  logic [31:0] status, nf_status;
  logic irq, jdata_load, rdata_load, nf_irq, nf_jload, nf_rload;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnv_status_flags #(.NUM_CH(NCH), .IS_FLT0(1'b1)) u_cnv_status_flags (
    .clk(clk), .rst_n(rst_n), .flt_en(flt_en),
    .jconv_done(jconv_done), .rconv_done(rconv_done),
    .jdata_rd(jdata_rd), .rdata_rd(rdata_rd),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .ckab_evt(ckab_evt), .scd_evt(scd_evt), .chan_synced(chan_synced),
    .irq_en(irq_en), .status(status), .irq(irq),
    .jdata_load(jdata_load), .rdata_load(rdata_load)
  );

  cnv_status_flags #(.NUM_CH(NCH), .IS_FLT0(1'b0)) u_cnv_status_flags_nf (
    .clk(clk), .rst_n(rst_n), .flt_en(flt_en),
    .jconv_done(jconv_done), .rconv_done(rconv_done),
    .jdata_rd(jdata_rd), .rdata_rd(rdata_rd),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .ckab_evt(ckab_evt), .scd_evt(scd_evt), .chan_synced(chan_synced),
    .irq_en(irq_en), .status(nf_status), .irq(nf_irq),
    .jdata_load(nf_jload), .rdata_load(nf_rload)
  );

  typedef struct {
    string       tag;
    logic [31:0] sts;
    logic        irq;
    logic        jld;
    logic        rld;
    logic [31:0] nf_sts;
    logic        nf_irq;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench flag model, built from the requirements
  logic m_jeoc, m_reoc, m_jovr, m_rovr;
  logic [NCH-1:0] m_ckab, m_scd;

  function automatic logic [31:0] m_status();
    logic [31:0] s = '0;
    s[0] = m_jeoc; s[1] = m_reoc; s[2] = m_jovr; s[3] = m_rovr;
    s[23:16] = m_ckab; s[31:24] = m_scd;
    return s;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    exp_t e;
    logic jld, rld, lo_irq;
    jld = flt_en & jconv_done & (~m_jeoc | jdata_rd);
    rld = flt_en & rconv_done & (~m_reoc | rdata_rd);
    lo_irq = (m_jeoc & irq_en[0]) | (m_reoc & irq_en[1]) | (m_jovr & irq_en[2]) | (m_rovr & irq_en[3]);
    e.tag = tag; e.sts = m_status(); e.jld = jld; e.rld = rld;
    e.irq = lo_irq | ((|m_ckab) & irq_en[4]) | ((|m_scd) & irq_en[5]);
    e.nf_sts = {28'h0, m_status()[3:0]};
    e.nf_irq = lo_irq;
    q.push_back(e);
    if (!flt_en) begin
      m_jeoc = 0; m_reoc = 0; m_jovr = 0; m_rovr = 0; m_ckab = '0; m_scd = '0;
    end else begin
      m_jovr = (jconv_done & m_jeoc & ~jdata_rd) | (m_jovr & ~(clr_wr & clr_wdata[2]));
      m_rovr = (rconv_done & m_reoc & ~rdata_rd) | (m_rovr & ~(clr_wr & clr_wdata[3]));
      m_jeoc = jconv_done | (m_jeoc & ~jdata_rd);
      m_reoc = rconv_done | (m_reoc & ~rdata_rd);
      m_ckab = ckab_evt | ~chan_synced | (m_ckab & ~(clr_wr ? clr_wdata[23:16] : 8'h00));
      m_scd  = scd_evt | (m_scd & ~(clr_wr ? clr_wdata[31:24] : 8'h00));
    end
    @(posedge clk); #1;
    jconv_done = 0; rconv_done = 0; jdata_rd = 0; rdata_rd = 0;
    clr_wr = 0; clr_wdata = '0; ckab_evt = '0; scd_evt = '0;
  endtask

  // monitor: compare each expected item at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "status", status, e.sts);
      chk(e.tag, "irq", {31'h0, irq}, {31'h0, e.irq});
      chk(e.tag, "jdata_load", {31'h0, jdata_load}, {31'h0, e.jld});
      chk(e.tag, "rdata_load", {31'h0, rdata_load}, {31'h0, e.rld});
      chk("R9", "reserved bits", {20'h0, status[15:4]}, 32'h0);
      chk("R10", "other-filter status", nf_status, e.nf_sts);
      chk("R10", "other-filter irq", {31'h0, nf_irq}, {31'h0, e.nf_irq});
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; flt_en = 0; jconv_done = 0; rconv_done = 0; jdata_rd = 0; rdata_rd = 0;
    clr_wr = 0; clr_wdata = '0; ckab_evt = '0; scd_evt = '0; chan_synced = '0; irq_en = '0;
    m_jeoc = 0; m_reoc = 0; m_jovr = 0; m_rovr = 0; m_ckab = '0; m_scd = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset status", status, 32'h0);
    chk("R1", "reset irq", {31'h0, irq}, 32'h0);
    @(posedge clk); #1; rst_n = 1;

    // R1: events while disabled are ignored
    jconv_done = 1; rconv_done = 1; scd_evt = 8'hFF; cyc("R1");
    cyc("R1");

    // R6: enable with unsynchronized channels pins clock-absence flags
    flt_en = 1; cyc("R6");
    clr_wr = 1; clr_wdata = 32'h00FF_0000; cyc("R6");
    chan_synced = 8'hF7; cyc("R6");
    clr_wr = 1; clr_wdata = 32'h00FF_0000; cyc("R6");
    clr_wr = 1; clr_wdata = 32'h0000_0000; cyc("R6");
    chan_synced = 8'hFF; cyc("R6");
    clr_wr = 1; clr_wdata = 32'h0008_0000; cyc("R6");
    ckab_evt = 8'h21; cyc("R6");
    clr_wr = 1; clr_wdata = 32'h0001_0000; cyc("R6");
    clr_wr = 1; clr_wdata = 32'h0020_0000; ckab_evt = 8'h20; cyc("R5");
    clr_wr = 1; clr_wdata = 32'h00FF_0000; cyc("R6");

    // R2 / R3 injected path
    jdata_rd = 1; cyc("R2");
    jconv_done = 1; cyc("R2");
    cyc("R2");
    jconv_done = 1; cyc("R3");
    jconv_done = 1; jdata_rd = 1; cyc("R5");
    jdata_rd = 1; cyc("R2");
    clr_wr = 1; clr_wdata = 32'hFFFF_FFFB; cyc("R4");
    clr_wr = 1; clr_wdata = 32'h0000_0004; cyc("R4");

    // R2 / R3 regular path
    rconv_done = 1; cyc("R2");
    rconv_done = 1; cyc("R3");
    rconv_done = 1; cyc("R3");
    rdata_rd = 1; clr_wr = 1; clr_wdata = 32'h0000_0008; rconv_done = 1; cyc("R5");
    rdata_rd = 1; cyc("R2");
    clr_wr = 1; clr_wdata = 32'h0000_0008; cyc("R4");

    // R7 short circuit
    scd_evt = 8'h81; cyc("R7");
    clr_wr = 1; clr_wdata = 32'h0100_0000; cyc("R7");
    clr_wr = 1; clr_wdata = 32'h8000_0000; scd_evt = 8'h80; cyc("R5");
    clr_wr = 1; clr_wdata = 32'h8000_0000; cyc("R7");

    // R8 interrupt enables, one source at a time
    jconv_done = 1; rconv_done = 1; scd_evt = 8'h02; ckab_evt = 8'h40; cyc("R8");
    jconv_done = 1; rconv_done = 1; cyc("R8");
    for (int b = 0; b < 6; b++) begin
      irq_en = 6'(1 << b); cyc("R8");
    end
    irq_en = 6'h00; cyc("R8");
    jdata_rd = 1; rdata_rd = 1; irq_en = 6'h03; cyc("R8");
    clr_wr = 1; clr_wdata = 32'hFFFF_FFFF; irq_en = 6'h3F; cyc("R8");
    irq_en = 6'h3F; cyc("R8");
    scd_evt = 8'h10; cyc("R8");
    irq_en = 6'h1F; cyc("R8");

    // R1 disable clears everything, including pending flags
    jconv_done = 1; rconv_done = 1; cyc("R1");
    flt_en = 0; jconv_done = 1; clr_wr = 1; clr_wdata = 32'h0000_000C; cyc("R1");
    cyc("R1");
    flt_en = 1; cyc("R1");
    cyc("R1");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule